// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block derives a periodic interrupt from a 32.768 kHz time base. A free-running 15-bit phase counter advances once per incoming 32 kHz tick. A 4-bit rate code picks a power-of-two period in ticks, and an enable bit gates the whole function. When the counter reaches a multiple of the selected period, the block emits a one-cycle set pulse for the periodic flag. It also raises its interrupt-request contribution, which stays high until the status register's read-clear strobe arrives.

Because the phase counter never restarts, events always land on period boundaries of the free-running count, not at fixed offsets from a rate write. A rate change is evaluated at once and takes effect at the next boundary of the new period. The block has no calendar, no alarm and no register bus. The surrounding register file supplies the rate code, the enable and the clear strobe.

Top module: `pdv_periodic_irq`

## Requirements
- R1: After reset the phase count is zero and both `per_set` and `irq_req` are low.
- R2: For rate codes 3 to 15 with the enable high, the period is 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R3: Rate codes 1 and 2 are remapped to codes 8 and 9, so they give periods of 128 and 256 ticks.
- R4: With rate code 0, or with `per_enable` low, no event is produced and `irq_req` is not raised.
- R5: The phase count advances only in cycles where `tick_32k` is high. An event occurs on the tick that brings the count to a multiple of the period, counted from reset.
- R6: A change of rate code takes effect at the next boundary of the new period. No extra or early pulse appears at the moment of the change.
- R7: Each event gives a `per_set` pulse exactly one clock long, in the clock after the tick, and sets `irq_req` in that same clock.
- R8: `irq_req` stays high until `flag_clr` is seen. A clear strobe with no event drops `irq_req` in the next clock.
- R9: When an event and `flag_clr` fall in the same cycle, the event wins and `irq_req` stays high.
- R10: The phase count wraps from 32767 to 0, and the wrap point counts as a boundary for every period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-clock pulse per 32.768 kHz period |
| rate_sel | input | 4 | Rate code; 0 turns the output off |
| per_enable | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Read-clear strobe from the status register |
| per_set | output | 1 | One-clock periodic-flag set pulse |
| irq_req | output | 1 | Interrupt-request contribution, held until cleared |

## Verification
The bound checker watches four things on every cycle. A pulse may follow only an enabled tick with a non-zero code. Every pulse must land where the phase count is on a boundary of the rate that was selected. The request must rise with each pulse. The hold and clear rules of the request must be obeyed. The checker cannot show the actual spacing of events for each code, the remap of the two low codes, or the first event after a rate change. The bench's vector table and directed scenarios show these by counting ticks between pulses.

// File: rtl/pdv_pkg.sv
package pdv_pkg;
   // Rate code arithmetic shared by the divider and its checker.
   localparam int unsigned PDV_RATE_W      = 4;
   localparam int unsigned PDV_CNT_W       = 15;
   localparam int unsigned PDV_REMAP_LIMIT = 2;
   localparam int unsigned PDV_REMAP_ADD   = 7;

   typedef enum logic [1:0] {
      PDV_OFF    = 2'b00,
      PDV_DIRECT = 2'b01,
      PDV_REMAP  = 2'b10
   } pdv_mode_e;

   // Effective code after the low-code remap.
   function automatic logic [PDV_RATE_W-1:0] pdv_eff_code(input logic [PDV_RATE_W-1:0] code);
      logic [PDV_RATE_W-1:0] r;
      if (code != '0 && code <= PDV_RATE_W'(PDV_REMAP_LIMIT))
         r = code + PDV_RATE_W'(PDV_REMAP_ADD);
      else
         r = code;
      return r;
   endfunction
endpackage

// File: rtl/pdv_rate_decode.sv
module pdv_rate_decode
   import pdv_pkg::*;
#(
   parameter int unsigned RATE_W      = PDV_RATE_W,
   parameter int unsigned CNT_W       = PDV_CNT_W,
   parameter int unsigned REMAP_LIMIT = PDV_REMAP_LIMIT,
   parameter int unsigned REMAP_ADD   = PDV_REMAP_ADD
) (
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              per_enable,
   output logic              active,
   output pdv_mode_e         mode,
   output logic [CNT_W-1:0]  phase_mask
);
   localparam int unsigned MAX_SHIFT = (1 << RATE_W) - 2;

   if (MAX_SHIFT >= CNT_W) begin : g_bad_width
      $error("pdv_rate_decode: CNT_W too small for RATE_W");
   end
   if (REMAP_LIMIT + REMAP_ADD >= (1 << RATE_W)) begin : g_bad_remap
      $error("pdv_rate_decode: remap exceeds code range");
   end

   logic [RATE_W-1:0] eff_code;
   logic [RATE_W-1:0] shift_amt;

   always_comb begin
      if (rate_sel == '0) begin
         mode     = PDV_OFF;
         eff_code = '0;
      end else if (rate_sel <= RATE_W'(REMAP_LIMIT)) begin
         mode     = PDV_REMAP;
         eff_code = rate_sel + RATE_W'(REMAP_ADD);
      end else begin
         mode     = PDV_DIRECT;
         eff_code = rate_sel;
      end
      shift_amt = (eff_code == '0) ? '0 : eff_code - 1'b1;
      active    = per_enable && (mode != PDV_OFF);
   end

   // One comparator per mask bit: bit i is inside the period field when i < shift.
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign phase_mask[i] = (i < int'(shift_amt));
   end
endmodule

// File: rtl/pdv_phase_count.sv
module pdv_phase_count #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_32k,
   output logic [CNT_W-1:0] phase_cnt,
   output logic [CNT_W-1:0] phase_next
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("pdv_phase_count: CNT_W must be at least 2");
   end

   // Natural wrap at 2**CNT_W.
   assign phase_next = phase_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_cnt <= '0;
      else if (tick_32k)
         phase_cnt <= phase_next;
   end
endmodule

// File: rtl/pdv_flag_gen.sv
module pdv_flag_gen #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_32k,
   input  logic             active,
   input  logic [CNT_W-1:0] phase_next,
   input  logic [CNT_W-1:0] phase_mask,
   input  logic             flag_clr,
   output logic             per_set,
   output logic             irq_req
);
   logic boundary;
   logic hit;

   // The rate is sampled at the tick itself, so a change never replays a boundary.
   assign boundary = ((phase_next & phase_mask) == '0);
   assign hit      = tick_32k && active && boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_set <= 1'b0;
         irq_req <= 1'b0;
      end else begin
         per_set <= hit;
         irq_req <= hit || (irq_req && !flag_clr);
      end
   end
endmodule

// File: rtl/pdv_periodic_irq.sv
module pdv_periodic_irq
   import pdv_pkg::*;
#(
   parameter int unsigned RATE_W = PDV_RATE_W,
   parameter int unsigned CNT_W  = PDV_CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              per_enable,
   input  logic              flag_clr,
   output logic              per_set,
   output logic              irq_req
);
   logic             active;
   pdv_mode_e        mode;
   logic [CNT_W-1:0] phase_mask;
   logic [CNT_W-1:0] phase_cnt;
   logic [CNT_W-1:0] phase_next;

   pdv_rate_decode #(
      .RATE_W      (RATE_W),
      .CNT_W       (CNT_W),
      .REMAP_LIMIT (PDV_REMAP_LIMIT),
      .REMAP_ADD   (PDV_REMAP_ADD)
   ) u_decode (
      .rate_sel   (rate_sel),
      .per_enable (per_enable),
      .active     (active),
      .mode       (mode),
      .phase_mask (phase_mask)
   );

   pdv_phase_count #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_32k   (tick_32k),
      .phase_cnt  (phase_cnt),
      .phase_next (phase_next)
   );

   pdv_flag_gen #(.CNT_W(CNT_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_32k   (tick_32k),
      .active     (active),
      .phase_next (phase_next),
      .phase_mask (phase_mask),
      .flag_clr   (flag_clr),
      .per_set    (per_set),
      .irq_req    (irq_req)
   );
endmodule

// File: rtl/pdv_periodic_irq_chk.sv
module pdv_periodic_irq_chk
   import pdv_pkg::*;
#(
   parameter int unsigned RATE_W = PDV_RATE_W,
   parameter int unsigned CNT_W  = PDV_CNT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_32k,
   input logic [RATE_W-1:0] rate_sel,
   input logic              per_enable,
   input logic              flag_clr,
   input logic              per_set,
   input logic              irq_req,
   input logic [CNT_W-1:0]  phase_cnt
);
   // The expected boundary mask is rebuilt here from the package function.
   logic [RATE_W-1:0] chk_code;
   logic [CNT_W-1:0]  chk_mask;
   always_comb begin
      chk_code = pdv_eff_code(rate_sel);
      for (int i = 0; i < CNT_W; i++)
         chk_mask[i] = (i + 1 < int'(chk_code));
   end

   AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      per_set |-> $past(tick_32k)); // R5
   AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      per_set |-> $past(per_enable && rate_sel != '0)); // R4
   AST_PULSE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      per_set |-> ((phase_cnt & $past(chk_mask)) == '0)); // R6
   AST_REQ_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      per_set |-> irq_req); // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !flag_clr) |=> irq_req); // R8
   AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> (!irq_req || per_set)); // R9
   AST_REQ_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> per_set); // R7
endmodule

bind pdv_periodic_irq pdv_periodic_irq_chk #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_32k   (tick_32k),
   .rate_sel   (rate_sel),
   .per_enable (per_enable),
   .flag_clr   (flag_clr),
   .per_set    (per_set),
   .irq_req    (irq_req),
   .phase_cnt  (phase_cnt)
);

// File: tb/tb_pdv_periodic_irq.sv
module tb_pdv_periodic_irq;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic [3:0] rate_sel = '0;
   logic       per_enable = 1'b0;
   logic       flag_clr = 1'b0;
   logic       per_set;
   logic       irq_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pdv_periodic_irq dut (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
      .per_enable(per_enable), .flag_clr(flag_clr), .per_set(per_set), .irq_req(irq_req)
   );

   typedef struct packed {
      logic [3:0]  code;
      logic        en;
      logic [16:0] ticks;
      logic [15:0] exp_events;
   } vec_t;

   // Expected counts: ticks / 2^(eff-1), with codes 1,2 acting as 8,9.
   localparam vec_t VECS [0:10] = '{
      '{4'd3,  1'b1, 17'd64,    16'd16}, // R2 period 4
      '{4'd4,  1'b1, 17'd64,    16'd8},  // R2 period 8
      '{4'd7,  1'b1, 17'd256,   16'd4},  // R2 period 64
      '{4'd14, 1'b1, 17'd16384, 16'd2},  // R2 period 8192
      '{4'd15, 1'b1, 17'd16384, 16'd1},  // R2 period 16384
      '{4'd1,  1'b1, 17'd512,   16'd4},  // R3 period 128
      '{4'd2,  1'b1, 17'd512,   16'd2},  // R3 period 256
      '{4'd8,  1'b1, 17'd512,   16'd4},  // R3 reference: code 8 equals code 1
      '{4'd0,  1'b1, 17'd256,   16'd0},  // R4 code zero
      '{4'd3,  1'b0, 17'd256,   16'd0},  // R4 enable low
      '{4'd15, 1'b1, 17'd32768, 16'd2}   // R10 wrap is a boundary
   };
   localparam string VREQ [0:10] = '{"R2","R2","R2","R2","R2","R3","R3","R3","R4","R4","R10"};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_32k = 1'b0; flag_clr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One cycle with given tick/clear; returns per_set sampled after the edge.
   task automatic step(input bit tk, input bit clr, output bit pulse);
      @(negedge clk);
      tick_32k = tk; flag_clr = clr;
      @(posedge clk);
      #1 pulse = per_set;
      @(negedge clk);
      tick_32k = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic run_ticks(input int n, output int events);
      bit p;
      events = 0;
      for (int i = 0; i < n; i++) begin
         step(1'b1, 1'b0, p);
         if (p) events++;
      end
   endtask

   // Ticks until the first pulse (inclusive), bounded.
   task automatic ticks_to_event(input int limit, output int k);
      bit p;
      k = -1;
      for (int i = 1; i <= limit; i++) begin
         step(1'b1, 1'b0, p);
         if (p) begin k = i; break; end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         finish_run();
      end
   end

   initial begin
      int ev, k;
      bit p;

      // R1: reset state
      do_reset();
      #1;
      check(per_set == 1'b0, "R1 per_set", per_set, 0);
      check(irq_req == 1'b0, "R1 irq_req", irq_req, 0);

      // Vector table
      for (int v = 0; v <= 10; v++) begin
         rate_sel = VECS[v].code; per_enable = VECS[v].en;
         do_reset();
         run_ticks(int'(VECS[v].ticks), ev);
         check(ev == int'(VECS[v].exp_events), VREQ[v], ev, int'(VECS[v].exp_events));
         if (VECS[v].exp_events == 0)
            check(irq_req == 1'b0, {VREQ[v], " irq"}, irq_req, 0);
      end

      // R5: idle cycles do not advance the phase
      rate_sel = 4'd3; per_enable = 1'b1;
      do_reset();
      run_ticks(3, ev);
      check(ev == 0, "R5 before boundary", ev, 0);
      ev = 0;
      for (int i = 0; i < 6; i++) begin step(1'b0, 1'b0, p); if (p) ev++; end
      check(ev == 0, "R5 idle no pulse", ev, 0);
      run_ticks(1, ev);
      check(ev == 1, "R5 fourth tick", ev, 1);

      // R7: pulse one clock, request raised
      check(irq_req == 1'b1, "R7 irq set", irq_req, 1);
      step(1'b0, 1'b0, p);
      check(p == 1'b0, "R7 pulse width", p, 0);

      // R8: hold then clear
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, p);
      #1 check(irq_req == 1'b1, "R8 hold", irq_req, 1);
      step(1'b0, 1'b1, p);
      #1 check(irq_req == 1'b0, "R8 clear", irq_req, 0);

      // R9: event and clear together (count at 4, next boundary at 8)
      run_ticks(3, ev);
      check(irq_req == 1'b0 && ev == 0, "R9 precondition", irq_req, 0);
      step(1'b1, 1'b1, p);
      #1 check(p == 1'b1 && irq_req == 1'b1, "R9 set wins", irq_req, 1);

      // R6: fast to slow; count 5 after reset, switch to period 8 -> event at 8
      rate_sel = 4'd3;
      do_reset();
      run_ticks(5, ev);
      check(ev == 1, "R6 first rate", ev, 1);
      rate_sel = 4'd4;
      ticks_to_event(20, k);
      check(k == 3, "R6 slow boundary", k, 3);

      // R6: slow to fast; count 10 with period 32, switch to period 4 -> event at 12
      rate_sel = 4'd6;
      do_reset();
      run_ticks(10, ev);
      check(ev == 0, "R6 slow idle", ev, 0);
      rate_sel = 4'd3;
      ticks_to_event(20, k);
      check(k == 2, "R6 fast boundary", k, 2);

      // R4: enable dropped exactly on a boundary tick
      rate_sel = 4'd3;
      do_reset();
      run_ticks(3, ev);
      per_enable = 1'b0;
      run_ticks(1, ev);
      check(ev == 0 && irq_req == 1'b0, "R4 disabled boundary", ev, 0);
      per_enable = 1'b1;

      done = 1;
      finish_run();
   end
endmodule